// File: doc/BRIEF.md
# Write-buffer program sequencer

This block is the device-side controller for a buffered program operation on a flash array. The host opens the operation by writing the byte E8h at any address inside the block it wants to program. The sequencer remembers that block and, while it waits for the next write, presents an extended status byte whose top bit says a write buffer is free. The next write gives a word count N in its low byte, and N+1 data writes follow. Each one is captured with its address into a small internal buffer.

Once the last word is in, the sequencer expects the confirm byte D0h. On that byte it commits the buffer to the array, one word per clock and in arrival order, with status bit 7 held low until the last word is written. A malformed sequence aborts the operation and latches a sequence error. Malformed means a count the buffer cannot hold, a data write outside the named block, or any other byte in the confirm slot. The error stays latched until the host writes the clear-status byte 50h while the sequencer is idle.

Top module: `wbuf_prog_seq`

## Requirements
- R1: While idle, a write whose low data byte is E8h starts the sequence at that address's block; until the next write, `rd_data` shows the extended status 80h (bit 7 = buffer available) whatever the error state.
- R2: The next write loads N from its low data byte, and N+1 data writes are then expected; from then on `rd_data` shows the status byte {bit 7 ready, bit 6 0, bit 5 error, bit 4 error, bits 3..0 0}.
- R3: A count N of DEPTH (16) or more aborts the sequence, sets status bits 5 and 4 (reads B0h) and causes no array write.
- R4: A data write whose address bits above the low BLK_W (6) bits differ from those of the E8h write aborts with status B0h and no array write.
- R5: Any byte other than D0h in the confirm slot aborts with status B0h and no array write.
- R6: After D0h, from the next cycle `busy` is 1 and status bit 7 is 0 for exactly N+1 cycles, after which status bit 7 returns to 1.
- R7: During programming, `arr_we` pulses once per cycle and writes each buffered word to its captured address, in the order received.
- R8: Bus writes that arrive while programming have no effect: they neither start a new sequence nor change the array writes or the status.
- R9: While idle, a write of 50h clears both error bits; any other idle byte except E8h leaves the status unchanged.
- R10: After reset `rd_data` is 80h, and `busy` and `arr_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | One-cycle bus write strobe |
| bus_addr | input | ADDR_W | Word address of the bus write |
| bus_wdata | input | DATA_W | Bus write data; commands and the count use the low byte |
| rd_data | output | 8 | Value a status read returns (extended or normal status) |
| busy | output | 1 | High while the buffer is being committed |
| arr_we | output | 1 | Array write strobe, one word per cycle |
| arr_addr | output | ADDR_W | Array word address |
| arr_data | output | DATA_W | Array write data |

## Verification
The properties take for granted that `bus_we` is a single-cycle strobe, with address and data stable around the sampling edge. They also assume the host sends nothing else to the array port, so the array is written only by this sequencer. The stimulus keeps to this by driving every bus write from one task that raises the strobe on a falling edge and drops it one cycle later, with an idle cycle between writes. Random counts, offsets, data and abort positions are drawn from a fixed seed and mixed with directed cases. These cover the smallest and largest legal counts, a count exactly equal to the depth, an abort on the first and on the last word, and a stray write during programming.

// File: rtl/wbuf_prog_pkg.sv
package wbuf_prog_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE    = 3'd0,
      SQ_COUNT   = 3'd1,
      SQ_FILL    = 3'd2,
      SQ_CONFIRM = 3'd3,
      SQ_PROGRAM = 3'd4
   } seq_state_e;

   localparam logic [7:0] OP_BUF_PROGRAM = 8'hE8;
   localparam logic [7:0] OP_CONFIRM     = 8'hD0;
   localparam logic [7:0] OP_CLEAR_STAT  = 8'h50;

   localparam logic [7:0] XSTAT_AVAIL    = 8'h80;

   function automatic logic [7:0] pack_status(input logic ready, input logic seq_err);
      return {ready, 1'b0, seq_err, seq_err, 4'b0000};
   endfunction

endpackage

// File: rtl/wbuf_blk_match.sv
module wbuf_blk_match #(
   parameter int BASE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [BASE_W-1:0] addr_hi,
   output logic [BASE_W-1:0] blk_q,
   output logic              in_block
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q <= '0;
      end else if (capture) begin
         blk_q <= addr_hi;
      end
   end

   assign in_block = (addr_hi == blk_q);

endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
   parameter int DEPTH  = 16,
   parameter int WORD_W = 32,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_word
);

   logic [WORD_W-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [WORD_W-1:0] ent_q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == IDX_W'(i))) begin
            ent_q <= wr_word;
         end
      end
      assign words[i] = ent_q;
   end

   assign rd_word = words[rd_idx];

endmodule

// File: rtl/wbuf_seq_fsm.sv
module wbuf_seq_fsm
   import wbuf_prog_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic [7:0]       cmd_byte,
   input  logic             in_block,
   output seq_state_e       state_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             err_o,
   output logic             capture_o,
   output logic             store_o
);

   seq_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] last_q;
   logic             err_q;
   logic             count_bad;

   assign count_bad = (int'(cmd_byte) >= DEPTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         idx_q   <= '0;
         last_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (bus_we) begin
                  if (cmd_byte == OP_BUF_PROGRAM) begin
                     state_q <= SQ_COUNT;
                  end else if (cmd_byte == OP_CLEAR_STAT) begin
                     err_q <= 1'b0;
                  end
               end
            end
            SQ_COUNT: begin
               if (bus_we) begin
                  if (count_bad) begin
                     err_q   <= 1'b1;
                     state_q <= SQ_IDLE;
                  end else begin
                     last_q  <= cmd_byte[IDX_W-1:0];
                     idx_q   <= '0;
                     state_q <= SQ_FILL;
                  end
               end
            end
            SQ_FILL: begin
               if (bus_we) begin
                  if (!in_block) begin
                     err_q   <= 1'b1;
                     state_q <= SQ_IDLE;
                  end else if (idx_q == last_q) begin
                     state_q <= SQ_CONFIRM;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            SQ_CONFIRM: begin
               if (bus_we) begin
                  if (cmd_byte == OP_CONFIRM) begin
                     idx_q   <= '0;
                     state_q <= SQ_PROGRAM;
                  end else begin
                     err_q   <= 1'b1;
                     state_q <= SQ_IDLE;
                  end
               end
            end
            SQ_PROGRAM: begin
               if (idx_q == last_q) begin
                  state_q <= SQ_IDLE;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign state_o   = state_q;
   assign idx_o     = idx_q;
   assign err_o     = err_q;
   assign capture_o = (state_q == SQ_IDLE) && bus_we && (cmd_byte == OP_BUF_PROGRAM);
   assign store_o   = (state_q == SQ_FILL) && bus_we && in_block;

endmodule

// File: rtl/wbuf_prog_seq.sv
module wbuf_prog_seq
   import wbuf_prog_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 16,
   parameter int BLK_W        = 6,
   parameter int DEPTH        = 16,
   parameter bit STORE_OFFSET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [7:0]        rd_data,
   output logic              busy,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_data
);

   localparam int BASE_W = ADDR_W - BLK_W;
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int ENT_AW = STORE_OFFSET ? BLK_W : ADDR_W;
   localparam int WORD_W = ENT_AW + DATA_W;

   if (BLK_W < 1 || BLK_W >= ADDR_W) begin : g_bad_blk
      $error("BLK_W must lie between 1 and ADDR_W-1");
   end
   if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
      $error("DEPTH must lie between 2 and 256");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be at least 8");
   end

   seq_state_e        state;
   logic [IDX_W-1:0]  idx;
   logic              seq_err;
   logic              capture;
   logic              store_en;
   logic              in_block;
   logic [BASE_W-1:0] blk_q;
   logic [ENT_AW-1:0] ent_addr_in;
   logic [ENT_AW-1:0] ent_addr_out;
   logic [WORD_W-1:0] ent_rd;

   wbuf_blk_match #(
      .BASE_W (BASE_W)
   ) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture),
      .addr_hi  (bus_addr[ADDR_W-1:BLK_W]),
      .blk_q    (blk_q),
      .in_block (in_block)
   );

   wbuf_seq_fsm #(
      .DEPTH (DEPTH)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .cmd_byte  (bus_wdata[7:0]),
      .in_block  (in_block),
      .state_o   (state),
      .idx_o     (idx),
      .err_o     (seq_err),
      .capture_o (capture),
      .store_o   (store_en)
   );

   wbuf_store #(
      .DEPTH  (DEPTH),
      .WORD_W (WORD_W)
   ) u_store (
      .clk     (clk),
      .wr_en   (store_en),
      .wr_idx  (idx),
      .wr_word ({ent_addr_in, bus_wdata}),
      .rd_idx  (idx),
      .rd_word (ent_rd)
   );

   assign ent_addr_out = ent_rd[WORD_W-1:DATA_W];
   assign arr_data     = ent_rd[DATA_W-1:0];

   if (STORE_OFFSET) begin : g_offset_entries
      assign ent_addr_in = bus_addr[BLK_W-1:0];
      assign arr_addr    = {blk_q, ent_addr_out};
   end else begin : g_full_entries
      assign ent_addr_in = bus_addr;
      assign arr_addr    = ent_addr_out;
   end

   assign busy    = (state == SQ_PROGRAM);
   assign arr_we  = (state == SQ_PROGRAM);
   assign rd_data = (state == SQ_COUNT) ? XSTAT_AVAIL : pack_status(~busy, seq_err);

endmodule

// File: rtl/wbuf_prog_seq_chk.sv
module wbuf_prog_seq_chk #(
   parameter int ADDR_W = 16,
   parameter int BLK_W  = 6,
   parameter int DEPTH  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [15:0]       bus_wdata,
   input logic [7:0]        rd_data,
   input logic              busy,
   input logic              arr_we,
   input logic [ADDR_W-1:0] arr_addr
);

   logic [15:0] burst_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_cnt <= '0;
      end else if (!busy) begin
         burst_cnt <= '0;
      end else if (arr_we) begin
         burst_cnt <= burst_cnt + 16'd1;
      end
   end

   // R6
   busy_needs_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(bus_we) && ($past(bus_wdata[7:0]) == 8'hD0)));

   // R6
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !rd_data[7]);

   // R7
   burst_one_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && $past(arr_we)) |-> (arr_addr[ADDR_W-1:BLK_W] == $past(arr_addr[ADDR_W-1:BLK_W])));

   // R3
   burst_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_cnt <= 16'(DEPTH));

   // R4
   err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[4] == rd_data[5]);

   // R5
   err_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[4]) |-> $past(bus_we));

   // R8
   busy_err_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(rd_data[5:4]));

endmodule

bind wbuf_prog_seq wbuf_prog_seq_chk #(
   .ADDR_W (ADDR_W),
   .BLK_W  (BLK_W),
   .DEPTH  (DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_wdata (16'(bus_wdata)),
   .rd_data   (rd_data),
   .busy      (busy),
   .arr_we    (arr_we),
   .arr_addr  (arr_addr)
);

// File: tb/wbuf_prog_seq_bench.sv
`timescale 1ns/1ps
module wbuf_prog_seq_bench;

   localparam int AW  = 16;
   localparam int DW  = 16;
   localparam int BW  = 6;
   localparam int DEP = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          bus_we;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [7:0]    rd_data;
   logic          busy;
   logic          arr_we;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] arr_data;

   always #2.5 clk = ~clk;

   wbuf_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .BLK_W(BW), .DEPTH(DEP)) u_wbuf_prog_seq (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .rd_data(rd_data), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [AW-1:0] mon_a [64];
   logic [DW-1:0] mon_d [64];
   int            mon_n = 0;
   int            bsy_n = 0;
   logic [AW-1:0] exp_a [64];
   logic [DW-1:0] exp_d [64];

   always @(negedge clk) begin
      if (busy) bsy_n++;
      if (arr_we && mon_n < 64) begin
         mon_a[mon_n] = arr_addr;
         mon_d[mon_n] = arr_data;
         mon_n++;
      end
   end

   function automatic logic [7:0] exp_status(input bit prog, input bit err);
      return {~prog, 1'b0, err, err, 4'b0000};
   endfunction

   function automatic logic [AW-1:0] rand_in_block(input logic [AW-1:0] base);
      return base | AW'($urandom_range(0, (1 << BW) - 1));
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_we    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic clr();
      wr(AW'($urandom), 16'h0050);
      chk(rd_data == exp_status(0, 0), "R9", "status after clear", rd_data, exp_status(0, 0));
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (busy && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   // mode 0 good, 1 out-of-block data, 2 bad confirm, 3 oversized count
   task automatic run_seq(input int n, input int mode, input int pos, input int big);
      logic [AW-1:0] base;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      base  = AW'($urandom) & ~AW'((1 << BW) - 1);
      mon_n = 0;
      bsy_n = 0;
      wr(rand_in_block(base), 16'h00E8);
      chk(rd_data == 8'h80, "R1", "extended status", rd_data, 8'h80);
      if (mode == 3) begin
         wr(base, DW'(big));
         chk(rd_data == exp_status(0, 1), "R3", "status after big count", rd_data, exp_status(0, 1));
         repeat (3) @(negedge clk);
         chk(mon_n == 0, "R3", "array writes", mon_n, 0);
         clr();
         return;
      end
      wr(base, DW'(n));
      chk(rd_data == exp_status(0, 0), "R2", "status after count", rd_data, exp_status(0, 0));
      for (int i = 0; i <= n; i++) begin
         a = rand_in_block(base);
         d = DW'($urandom);
         if (mode == 1 && i == pos) begin
            a = a ^ (AW'(1) << BW);
            wr(a, d);
            chk(rd_data == exp_status(0, 1), "R4", "status after foreign address", rd_data, exp_status(0, 1));
            repeat (3) @(negedge clk);
            chk(mon_n == 0, "R4", "array writes", mon_n, 0);
            clr();
            return;
         end
         wr(a, d);
         exp_a[i] = a;
         exp_d[i] = d;
      end
      if (mode == 2) begin
         wr(base, 16'h00FF);
         chk(rd_data == exp_status(0, 1), "R5", "status after bad confirm", rd_data, exp_status(0, 1));
         repeat (3) @(negedge clk);
         chk(mon_n == 0, "R5", "array writes", mon_n, 0);
         clr();
         return;
      end
      wr(base, 16'h00D0);
      chk(busy == 1'b1, "R6", "busy after confirm", busy, 1);
      chk(rd_data == exp_status(1, 0), "R6", "status while programming", rd_data, exp_status(1, 0));
      if (n >= 2) wr(rand_in_block(base), 16'h00E8);
      wait_idle();
      chk(bsy_n == n + 1, "R6", "busy cycles", bsy_n, n + 1);
      chk(rd_data == exp_status(0, 0), "R6", "status after programming", rd_data, exp_status(0, 0));
      chk(mon_n == n + 1, "R7", "array write count", mon_n, n + 1);
      for (int i = 0; i <= n && i < mon_n; i++) begin
         chk(mon_a[i] == exp_a[i], "R7", "array address", mon_a[i], exp_a[i]);
         chk(mon_d[i] == exp_d[i], "R7", "array data", mon_d[i], exp_d[i]);
      end
      wr(base, 16'h0020);
      chk(rd_data == exp_status(0, 0), "R8", "no sequence started during programming", rd_data, exp_status(0, 0));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5171));
      rst_n     = 1'b0;
      bus_we    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10
      chk(rd_data == 8'h80, "R10", "reset status", rd_data, 8'h80);
      chk(busy == 1'b0, "R10", "reset busy", busy, 0);
      chk(arr_we == 1'b0, "R10", "reset array strobe", arr_we, 0);

      // directed corners
      run_seq(0, 0, 0, 0);
      run_seq(DEP - 1, 0, 0, 0);
      run_seq(0, 3, 0, DEP);
      run_seq(0, 3, 0, 255);
      run_seq(4, 1, 0, 0);
      run_seq(5, 1, 5, 0);
      run_seq(3, 2, 0, 0);

      // R9 other idle bytes leave a latched error in place
      wr(16'h0000, 16'h00E8);
      wr(16'h0000, 16'h0030);
      wr(16'h0100, 16'h0012);
      chk(rd_data == exp_status(0, 1), "R9", "error kept after unrelated byte", rd_data, exp_status(0, 1));
      // R1 extended view hides the error; R2 normal view shows it
      mon_n = 0;
      wr(16'h0040, 16'h00E8);
      chk(rd_data == 8'h80, "R1", "extended status with error latched", rd_data, 8'h80);
      wr(16'h0040, 16'h0000);
      chk(rd_data == exp_status(0, 1), "R2", "normal status with error latched", rd_data, exp_status(0, 1));
      wr(16'h0041, 16'hBEEF);
      wr(16'h0000, 16'h00D0);
      chk(rd_data == exp_status(1, 1), "R6", "programming with error latched", rd_data, exp_status(1, 1));
      wait_idle();
      chk(mon_n == 1, "R7", "single word count", mon_n, 1);
      chk(mon_a[0] == 16'h0041, "R7", "single word address", mon_a[0], 16'h0041);
      chk(mon_d[0] == 16'hBEEF, "R7", "single word data", mon_d[0], 16'hBEEF);
      clr();

      // random mix
      for (int k = 0; k < 40; k++) begin
         int n;
         int mode;
         n    = $urandom_range(0, DEP - 1);
         mode = $urandom_range(0, 5);
         if (mode > 3) mode = 0;
         run_seq(n, mode, $urandom_range(0, n), $urandom_range(DEP, 255));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule